// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block opens and closes the transmission gates of eight traffic-class queues on one egress port, following a repeating time schedule. Software loads it through a 16-bit register write port. The load covers a list of schedule entries, a cycle length, the gate states that every cycle begins with, and a start instant. Each entry holds a toggle mask and a duration in nanoseconds. The start instant is given as nanoseconds plus the low three bits of the synchronized seconds count, so a start can lie at most eight seconds ahead of the present time.

Until a schedule is launched, or whenever gating is switched off, the gates show a set of fallback states kept in the control register. At reset these states are all open. Once the armed start instant matches the time input, the block loads the initial states and starts timing the first entry. When the running entry's duration has elapsed, its mask is XORed into the gates and the next entry takes over. The list stops at the entry flagged as last. At every cycle boundary the block reloads the initial states and returns to entry 0.

The block counts elapsed time internally, adding `NS_STEP` nanoseconds per clock. The time input is used only to decide when the schedule starts.

Top module: `tgate_sched`

## Requirements
- R1: After reset `gate_open` is all ones, gating is disabled and no start is armed.
- R2: Writing register 0 sets bit 0 as gate enable and bits 15:8 as the fallback states. While enable is 0, or before any schedule has launched, `gate_open` equals the fallback states from the clock after the write.
- R3: Writing register 1 stages a toggle mask (bits 7:0) and a last flag (bit 15). Registers 2 and 3 stage the low and high 16-bit halves of an entry duration. Writing register 4 stores the staged entry at the index in bits 15:8 and latches bits 7:0 as the initial gate states. Registers 5 and 6 hold the low and high halves of the cycle length.
- R4: Registers 7 and 8 hold the low 16 bits and bits 29:16 (written in bits 13:0) of the start nanoseconds. Register 9 holds arm (bit 0), switch (bit 1) and seconds (bits 4:2). A launch occurs at the first clock edge where the block is armed, switch is set, `now_sec_lo` equals the seconds field and `now_ns` equals the start nanoseconds. From that edge `gate_open` shows the initial states while gating is enabled.
- R5: If the seconds field differs from `now_sec_lo`, matching nanoseconds do not launch.
- R6: Writing 0 to register 9 cancels a pending start.
- R7: The arm bit clears when the start fires, so the same time value seen later does not relaunch.
- R8: A start armed with the switch bit clear is consumed when it fires but leaves the gates unchanged.
- R9: When the current entry's duration has elapsed since that entry began, its mask is XORed into the gates and the next index becomes current.
- R10: After the entry flagged last has applied its mask, the gates hold until the cycle boundary. Entries stored above it are not used.
- R11: When the elapsed time in the cycle reaches the cycle length, the gates reload the initial states and entry 0 restarts. This reload takes precedence over any entry expiring on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| now_sec_lo | input | 3 | Low bits of synchronized seconds |
| now_ns | input | 30 | Synchronized nanoseconds within the second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 16 | Register write data |
| gate_open | output | 8 | Per-class gate open, bit n for class n |

## Verification
The assertions take the following for granted:
- Every entry duration and the cycle length are nonzero multiples of `NS_STEP`.
- The time input moves forward by `NS_STEP` each clock, except where a deliberate jump is made.
- A launch and a write to the start command never fall on the same clock.

The stimulus keeps within these limits. It uses durations of 30, 50 and 20 ns and a 120 ns cycle, advances `now_ns` by 10 ns per clock and finishes each command write well before its start instant. The only time jump moves `now_ns` backwards after the start has fired, and it is there to show that the start does not fire again.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] A_CTRL      = 4'd0;
   localparam logic [REG_AW-1:0] A_ENT_MASK  = 4'd1;
   localparam logic [REG_AW-1:0] A_ENT_IVL_L = 4'd2;
   localparam logic [REG_AW-1:0] A_ENT_IVL_H = 4'd3;
   localparam logic [REG_AW-1:0] A_ENT_PUT   = 4'd4;
   localparam logic [REG_AW-1:0] A_CYC_L     = 4'd5;
   localparam logic [REG_AW-1:0] A_CYC_H     = 4'd6;
   localparam logic [REG_AW-1:0] A_GO_NS_L   = 4'd7;
   localparam logic [REG_AW-1:0] A_GO_NS_H   = 4'd8;
   localparam logic [REG_AW-1:0] A_GO_CMD    = 4'd9;

   localparam int EN_BIT    = 0;
   localparam int FALLB_LSB = 8;
   localparam int LAST_BIT  = 15;
   localparam int IDX_LSB   = 8;
   localparam int ARM_BIT   = 0;
   localparam int SW_BIT    = 1;
   localparam int SEC_LSB   = 2;
endpackage

// File: rtl/tgs_regs.sv
module tgs_regs
   import tgs_pkg::*;
#(
   parameter int NUM_GATES   = 8,
   parameter int LIST_DEPTH  = 8,
   parameter int IVL_W       = 32,
   parameter int CYC_W       = 32,
   parameter int NS_W        = 30,
   parameter int SEC_FIELD_W = 3,
   parameter int DATA_W      = 16,
   localparam int LIST_AW    = $clog2(LIST_DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [REG_AW-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   output logic                   gate_en,
   output logic [NUM_GATES-1:0]   fallback,
   output logic [NUM_GATES-1:0]   stage_mask,
   output logic                   stage_last,
   output logic [IVL_W-1:0]       stage_ivl,
   output logic                   put,
   output logic [LIST_AW-1:0]     put_idx,
   output logic [NUM_GATES-1:0]   init_states,
   output logic [CYC_W-1:0]       cycle_len,
   output logic [NS_W-1:0]        go_ns,
   output logic                   cmd_wr,
   output logic                   cmd_arm,
   output logic                   cmd_sw,
   output logic [SEC_FIELD_W-1:0] cmd_sec
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_en     <= 1'b0;
         fallback    <= '1;
         stage_mask  <= '0;
         stage_last  <= 1'b0;
         stage_ivl   <= '0;
         init_states <= '0;
         cycle_len   <= '0;
         go_ns       <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: begin
               gate_en  <= wr_data[EN_BIT];
               fallback <= wr_data[FALLB_LSB +: NUM_GATES];
            end
            A_ENT_MASK: begin
               stage_mask <= wr_data[NUM_GATES-1:0];
               stage_last <= wr_data[LAST_BIT];
            end
            A_ENT_IVL_L: stage_ivl[DATA_W-1:0]     <= wr_data;
            A_ENT_IVL_H: stage_ivl[IVL_W-1:DATA_W] <= wr_data[IVL_W-DATA_W-1:0];
            A_ENT_PUT:   init_states               <= wr_data[NUM_GATES-1:0];
            A_CYC_L:     cycle_len[DATA_W-1:0]     <= wr_data;
            A_CYC_H:     cycle_len[CYC_W-1:DATA_W] <= wr_data[CYC_W-DATA_W-1:0];
            A_GO_NS_L:   go_ns[DATA_W-1:0]         <= wr_data;
            A_GO_NS_H:   go_ns[NS_W-1:DATA_W]      <= wr_data[NS_W-DATA_W-1:0];
            default: ;
         endcase
      end
   end

   assign put     = wr_en && (wr_addr == A_ENT_PUT);
   assign put_idx = wr_data[IDX_LSB +: LIST_AW];
   assign cmd_wr  = wr_en && (wr_addr == A_GO_CMD);
   assign cmd_arm = wr_data[ARM_BIT];
   assign cmd_sw  = wr_data[SW_BIT];
   assign cmd_sec = wr_data[SEC_LSB +: SEC_FIELD_W];
endmodule

// File: rtl/tgs_list.sv
module tgs_list #(
   parameter int NUM_GATES  = 8,
   parameter int LIST_DEPTH = 8,
   parameter int IVL_W      = 32,
   localparam int LIST_AW   = $clog2(LIST_DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [LIST_AW-1:0]   waddr,
   input  logic [NUM_GATES-1:0] wmask,
   input  logic                 wlast,
   input  logic [IVL_W-1:0]     wivl,
   input  logic [LIST_AW-1:0]   raddr,
   output logic [NUM_GATES-1:0] rmask,
   output logic                 rlast,
   output logic [IVL_W-1:0]     rivl
);
   logic [NUM_GATES-1:0] mask_q [LIST_DEPTH];
   logic                 last_q [LIST_DEPTH];
   logic [IVL_W-1:0]     ivl_q  [LIST_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LIST_DEPTH; i++) begin
            mask_q[i] <= '0;
            last_q[i] <= 1'b0;
            ivl_q[i]  <= '0;
         end
      end else if (we) begin
         for (int i = 0; i < LIST_DEPTH; i++) begin
            if (waddr == LIST_AW'(i)) begin
               mask_q[i] <= wmask;
               last_q[i] <= wlast;
               ivl_q[i]  <= wivl;
            end
         end
      end
   end

   assign rmask = mask_q[raddr];
   assign rlast = last_q[raddr];
   assign rivl  = ivl_q[raddr];
endmodule

// File: rtl/tgs_start.sv
module tgs_start #(
   parameter int NS_W        = 30,
   parameter int SEC_FIELD_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SEC_FIELD_W-1:0] now_sec_lo,
   input  logic [NS_W-1:0]        now_ns,
   input  logic [NS_W-1:0]        go_ns,
   input  logic                   cmd_wr,
   input  logic                   cmd_arm,
   input  logic                   cmd_sw,
   input  logic [SEC_FIELD_W-1:0] cmd_sec,
   output logic                   launch
);
   logic                   armed_q;
   logic                   sw_q;
   logic [SEC_FIELD_W-1:0] sec_q;
   logic                   fire;

   assign fire   = armed_q && (now_sec_lo == sec_q) && (now_ns == go_ns);
   assign launch = fire && sw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         sw_q    <= 1'b0;
         sec_q   <= '0;
      end else if (cmd_wr) begin
         armed_q <= cmd_arm;
         sw_q    <= cmd_sw;
         sec_q   <= cmd_sec;
      end else if (fire) begin
         armed_q <= 1'b0;
      end
   end

   // R7
   arm_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !cmd_wr) |=> !armed_q);

   // R6
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_arm) |=> (!armed_q && !launch));
endmodule

// File: rtl/tgs_engine.sv
module tgs_engine #(
   parameter int NUM_GATES  = 8,
   parameter int LIST_DEPTH = 8,
   parameter int IVL_W      = 32,
   parameter int CYC_W      = 32,
   parameter int NS_STEP    = 10,
   localparam int LIST_AW   = $clog2(LIST_DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch,
   input  logic [NUM_GATES-1:0] init_states,
   input  logic [CYC_W-1:0]     cycle_len,
   input  logic [NUM_GATES-1:0] ent_mask,
   input  logic                 ent_last,
   input  logic [IVL_W-1:0]     ent_ivl,
   output logic [LIST_AW-1:0]   rd_idx,
   output logic [NUM_GATES-1:0] oper_states,
   output logic                 running
);
   localparam logic [CYC_W:0]       CSTEP = (CYC_W+1)'(NS_STEP);
   localparam logic [IVL_W:0]       ISTEP = (IVL_W+1)'(NS_STEP);
   localparam logic [LIST_AW-1:0]   TOP_IDX = LIST_AW'(LIST_DEPTH-1);

   logic                 run_q;
   logic [CYC_W-1:0]     cyc_q;
   logic [IVL_W-1:0]     ivl_q;
   logic [LIST_AW-1:0]   idx_q;
   logic                 done_q;
   logic [NUM_GATES-1:0] oper_q;

   logic [CYC_W:0] cyc_nx;
   logic [IVL_W:0] ivl_nx;
   logic           wrap;
   logic           expire;
   logic           at_end;

   assign cyc_nx = {1'b0, cyc_q} + CSTEP;
   assign ivl_nx = {1'b0, ivl_q} + ISTEP;
   assign wrap   = cyc_nx >= {1'b0, cycle_len};
   assign expire = !done_q && (ivl_nx >= {1'b0, ent_ivl});
   assign at_end = ent_last || (idx_q == TOP_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cyc_q  <= '0;
         ivl_q  <= '0;
         idx_q  <= '0;
         done_q <= 1'b0;
         oper_q <= '1;
      end else if (launch || (run_q && wrap)) begin
         run_q  <= 1'b1;
         cyc_q  <= '0;
         ivl_q  <= '0;
         idx_q  <= '0;
         done_q <= 1'b0;
         oper_q <= init_states;
      end else if (run_q) begin
         cyc_q <= cyc_nx[CYC_W-1:0];
         if (expire) begin
            oper_q <= oper_q ^ ent_mask;
            ivl_q  <= '0;
            if (at_end) done_q <= 1'b1;
            else        idx_q  <= idx_q + 1'b1;
         end else if (!done_q) begin
            ivl_q <= ivl_nx[IVL_W-1:0];
         end
      end
   end

   assign rd_idx      = idx_q;
   assign oper_states = oper_q;
   assign running     = run_q;

   // R4
   launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (oper_q == $past(init_states)) && (cyc_q == '0) && run_q);

   // R10
   hold_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && done_q && !wrap && !launch) |=> $stable(oper_q));

   // R11
   wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && wrap && !launch) |=> (idx_q == '0) && !done_q
                                     && (oper_q == $past(init_states)));

   // R9
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !wrap && !launch && expire && !at_end) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/tgate_sched.sv
module tgate_sched
   import tgs_pkg::*;
#(
   parameter int NUM_GATES   = 8,
   parameter int LIST_DEPTH  = 8,
   parameter int IVL_W       = 32,
   parameter int CYC_W       = 32,
   parameter int NS_W        = 30,
   parameter int SEC_FIELD_W = 3,
   parameter int DATA_W      = 16,
   parameter int NS_STEP     = 10,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SEC_FIELD_W-1:0] now_sec_lo,
   input  logic [NS_W-1:0]        now_ns,
   input  logic                   wr_en,
   input  logic [REG_AW-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [NUM_GATES-1:0]   gate_open
);
   localparam int LIST_AW = $clog2(LIST_DEPTH);

   if (DATA_W != 16) begin : g_bad_data
      $error("tgate_sched: DATA_W must be 16");
   end
   if (NUM_GATES < 1 || NUM_GATES > 8) begin : g_bad_gates
      $error("tgate_sched: NUM_GATES must be 1..8");
   end
   if (LIST_DEPTH < 2 || LIST_AW > 8) begin : g_bad_depth
      $error("tgate_sched: LIST_DEPTH must be 2..256");
   end
   if (IVL_W <= DATA_W || IVL_W > 2*DATA_W || CYC_W <= DATA_W || CYC_W > 2*DATA_W
       || NS_W <= DATA_W || NS_W > 2*DATA_W) begin : g_bad_widths
      $error("tgate_sched: wide values must take two register halves");
   end
   if (NS_STEP < 1) begin : g_bad_step
      $error("tgate_sched: NS_STEP must be positive");
   end

   logic                   gate_en;
   logic [NUM_GATES-1:0]   fallback;
   logic [NUM_GATES-1:0]   stage_mask;
   logic                   stage_last;
   logic [IVL_W-1:0]       stage_ivl;
   logic                   put;
   logic [LIST_AW-1:0]     put_idx;
   logic [NUM_GATES-1:0]   init_states;
   logic [CYC_W-1:0]       cycle_len;
   logic [NS_W-1:0]        go_ns;
   logic                   cmd_wr, cmd_arm, cmd_sw;
   logic [SEC_FIELD_W-1:0] cmd_sec;
   logic                   launch;
   logic [LIST_AW-1:0]     rd_idx;
   logic [NUM_GATES-1:0]   ent_mask;
   logic                   ent_last;
   logic [IVL_W-1:0]       ent_ivl;
   logic [NUM_GATES-1:0]   oper_states;
   logic                   running;
   logic [NUM_GATES-1:0]   gate_nx;

   tgs_regs #(
      .NUM_GATES(NUM_GATES), .LIST_DEPTH(LIST_DEPTH), .IVL_W(IVL_W), .CYC_W(CYC_W),
      .NS_W(NS_W), .SEC_FIELD_W(SEC_FIELD_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .gate_en(gate_en), .fallback(fallback), .stage_mask(stage_mask),
      .stage_last(stage_last), .stage_ivl(stage_ivl), .put(put), .put_idx(put_idx),
      .init_states(init_states), .cycle_len(cycle_len), .go_ns(go_ns),
      .cmd_wr(cmd_wr), .cmd_arm(cmd_arm), .cmd_sw(cmd_sw), .cmd_sec(cmd_sec)
   );

   tgs_list #(
      .NUM_GATES(NUM_GATES), .LIST_DEPTH(LIST_DEPTH), .IVL_W(IVL_W)
   ) u_list (
      .clk(clk), .rst_n(rst_n), .we(put), .waddr(put_idx), .wmask(stage_mask),
      .wlast(stage_last), .wivl(stage_ivl), .raddr(rd_idx), .rmask(ent_mask),
      .rlast(ent_last), .rivl(ent_ivl)
   );

   tgs_start #(
      .NS_W(NS_W), .SEC_FIELD_W(SEC_FIELD_W)
   ) u_start (
      .clk(clk), .rst_n(rst_n), .now_sec_lo(now_sec_lo), .now_ns(now_ns),
      .go_ns(go_ns), .cmd_wr(cmd_wr), .cmd_arm(cmd_arm), .cmd_sw(cmd_sw),
      .cmd_sec(cmd_sec), .launch(launch)
   );

   tgs_engine #(
      .NUM_GATES(NUM_GATES), .LIST_DEPTH(LIST_DEPTH), .IVL_W(IVL_W), .CYC_W(CYC_W),
      .NS_STEP(NS_STEP)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .launch(launch), .init_states(init_states),
      .cycle_len(cycle_len), .ent_mask(ent_mask), .ent_last(ent_last),
      .ent_ivl(ent_ivl), .rd_idx(rd_idx), .oper_states(oper_states),
      .running(running)
   );

   assign gate_nx = (gate_en && running) ? oper_states : fallback;

   if (OUT_REG) begin : g_out_reg
      logic [NUM_GATES-1:0] gate_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gate_q <= '1;
         else        gate_q <= gate_nx;
      end
      assign gate_open = gate_q;
   end else begin : g_out_comb
      assign gate_open = gate_nx;
   end

   // R2
   fallback_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!OUT_REG && !gate_en) |-> (gate_open == fallback));
endmodule

// File: tb/tgate_sched_tb.sv
module tgate_sched_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  now_sec_lo;
   logic [29:0] now_ns;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  gate_open;

   int ns_r = 0;
   int sec_r = 5;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   localparam int GO = 2000;
   localparam int VEC_N = 13;
   localparam int VEC_E [VEC_N] = '{0, 20, 30, 70, 80, 90, 100, 110, 120, 140, 150, 200, 230};
   localparam logic [7:0] VEC_G [VEC_N] =
      '{8'h0F, 8'h0F, 8'h0C, 8'h0C, 8'h3C, 8'h3C, 8'h0F, 8'h0F, 8'h0F, 8'h0F, 8'h0C, 8'h3C, 8'h0F};
   localparam int VEC_R [VEC_N] = '{4, 9, 9, 9, 9, 9, 9, 10, 11, 11, 11, 11, 10};

   assign now_ns     = ns_r[29:0];
   assign now_sec_lo = sec_r[2:0];

   always #5 clk = ~clk;

   tgate_sched u_dut (
      .clk(clk), .rst_n(rst_n), .now_sec_lo(now_sec_lo), .now_ns(now_ns),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .gate_open(gate_open)
   );

   task automatic step();
      @(posedge clk);
      #1;
      ns_r = ns_r + 10;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic chk(input string req, input logic [7:0] exp);
      n_chk++;
      if (gate_open !== exp) begin
         n_err++;
         $display("FAIL %s: gate_open=%02h expected %02h", req, gate_open, exp);
      end
   endtask

   task automatic run_until(input int t);
      while ((ns_r - 10) < t) step();
   endtask

   // Gate states expected from elapsed ns since launch: initial 0F, toggles
   // 03 after 30, 30 after 50 more, 33 (last) after 20 more, cycle 120.
   function automatic logic [7:0] model(input int e);
      int m = e % 120;
      logic [7:0] g = 8'h0F;
      if (m >= 30)  g ^= 8'h03;
      if (m >= 80)  g ^= 8'h30;
      if (m >= 100) g ^= 8'h33;
      return g;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      int e_now;
      repeat (3) step();
      chk("R1 in reset", 8'hFF);
      rst_n = 1'b1;
      ns_r = 0;
      step();
      chk("R1 after reset", 8'hFF);

      // R2: fallback shown while disabled
      wr(4'd0, 16'hA500);
      chk("R2 fallback A5", 8'hA5);

      // R3: program list, entry 3 is unused trap above the last entry
      wr(4'd1, 16'h0003); wr(4'd2, 16'd30); wr(4'd3, 16'd0); wr(4'd4, 16'h000F);
      wr(4'd1, 16'h0030); wr(4'd2, 16'd50); wr(4'd3, 16'd0); wr(4'd4, 16'h010F);
      wr(4'd1, 16'h8033); wr(4'd2, 16'd20); wr(4'd3, 16'd0); wr(4'd4, 16'h020F);
      wr(4'd1, 16'h00F0); wr(4'd2, 16'd10); wr(4'd3, 16'd0); wr(4'd4, 16'h030F);
      wr(4'd5, 16'd120);  wr(4'd6, 16'd0);
      wr(4'd0, 16'hFF01);
      chk("R2 enabled, not launched", 8'hFF);

      // R8: switch bit clear
      wr(4'd7, 16'd600); wr(4'd8, 16'd0); wr(4'd9, 16'h0015);
      run_until(700);
      chk("R8 no switch", 8'hFF);

      // R5: seconds mismatch (field 6, now 5)
      wr(4'd7, 16'd1000); wr(4'd9, 16'h001B);
      run_until(1100);
      chk("R5 sec mismatch", 8'hFF);

      // R6: cancel
      wr(4'd7, 16'd1500); wr(4'd9, 16'h0017); wr(4'd9, 16'h0000);
      run_until(1600);
      chk("R6 cancel", 8'hFF);

      // Main launch at sec 5, ns 2000
      wr(4'd7, 16'(GO)); wr(4'd9, 16'h0017);
      for (int i = 0; i < VEC_N; i++) begin
         run_until(GO + VEC_E[i]);
         chk($sformatf("R%0d e=%0d", VEC_R[i], VEC_E[i]), VEC_G[i]);
      end

      // R2: disabling returns fallback while the cycle keeps running
      wr(4'd0, 16'h5A00);
      chk("R2 disable mid-run", 8'h5A);
      wr(4'd0, 16'hFF01);
      chk("R2 re-enable", model(ns_r - 10 - GO));

      // R7: arm consumed, replaying the start time does not relaunch
      while (((ns_r - 10 - GO) % 120) != 40) step();
      e_now = ns_r - 10 - GO;
      ns_r = GO;
      step();
      chk("R7 replay +10", model(e_now + 10));
      step();
      chk("R7 replay +20", model(e_now + 20));

      // R1: reset mid-run
      rst_n = 1'b0;
      step();
      chk("R1 reset mid-run", 8'hFF);
      rst_n = 1'b1;
      step();
      chk("R1 after second reset", 8'hFF);

      finish_run();
   end
endmodule